// File: doc/BRIEF.md
# Karatsuba GF(2^128) Field Multiplier

This block multiplies two elements of the binary field GF(2^128) and returns the reduced product. Each element is a 128-bit vector in which bit i holds the coefficient of x^i. A pulse on `start` captures both operands. The block then cuts each operand into a high and a low 64-bit half. It forms three 64x64 carryless products: low times low, high times high, and the XOR of the halves of one operand times the XOR of the halves of the other. It corrects the middle product by XORing the outer two into it. It then overlaps the three products into a 256-bit polynomial.

A shift-and-XOR long division reduces that polynomial modulo x^128 + x^7 + x^2 + x + 1. The division works from the top degree downwards. Each set coefficient at degree k >= 128 is folded onto degrees k-128, k-127, k-126 and k-121. The fold for a top degree can land new set bits at degree 128 or above. Working from the top down means those bits are folded later in the same pass.

The parameter `PARALLEL` picks the arithmetic arrangement. With the default value 0, a small controller time-shares one 64x64 carryless multiplier. It issues the three sub-products in the order low, middle, high, one per cycle, and a fourth cycle reduces and registers the result. With `PARALLEL` set to 1, three multipliers work in the same cycle and the latency falls to two cycles. `done` pulses for one cycle when `result` is updated, and `result` holds its value until the next completion.

Top module: `gf128_kmul`

## Requirements
- R1: While `rst` is high, and after it is released, `done` is 0 and `result` is all zeros until the first completion.
- R2: With the default `PARALLEL` = 0, `done` goes high exactly 4 clock edges after the edge that samples an accepted `start`. With `PARALLEL` = 1 this is 2 edges. `done` stays high for exactly one cycle.
- R3: When `done` is high, `result` equals a*b reduced modulo x^128 + x^7 + x^2 + x + 1. Bit i of `a`, `b` and `result` is the coefficient of x^i, and the addition of coefficients is XOR.
- R4: If either operand equals the element 1 (value 128'h1), the result equals the other operand unchanged.
- R5: If either operand is zero, the result is zero.
- R6: A `start` that arrives while a multiplication is in progress is ignored. Only one `done` pulse follows, and it carries the product of the operands accepted first.
- R7: `result` keeps its value in every cycle in which `done` is low.
- R8: Products that contain terms of degree 249 to 254 are reduced fully. In these products the first fold creates further bits at degree 128 or above, and these are folded as well. Example operands: a = b = x^127.
- R9: The operands are captured on the accepted `start` edge. Changing `a` or `b` afterwards has no effect on that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiplication; accepted only when the block is idle |
| a | input | 128 | First field element, bit i = coefficient of x^i |
| b | input | 128 | Second field element, bit i = coefficient of x^i |
| done | output | 1 | One-cycle pulse when `result` has just been updated |
| result | output | 128 | Reduced product, held until the next completion |

## Verification
The hardest case to reach from the ports is the cascade inside the reduction. A fold from degrees 249 to 254 lands back at degree 128 or above, and only a second fold in the same pass clears it. Ordinary random operands seldom set those top bits in a way that shows a missing second fold. The stimulus therefore drives operands with bit 127 and its neighbours set, such as x^127 times x^127 and all-ones times all-ones. Each result is compared against a bench model that multiplies one bit at a time and reduces at every step. The model never builds a 256-bit intermediate, so it does not share the block's method. A second case that is hard to reach is a request issued in the middle of the sub-product sequence. The bench holds `start` high with new operands during the middle-product cycles and counts the `done` pulses.

// File: rtl/gf128_kmul_pkg.sv
package gf128_kmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_RED  = 2'd2
  } kmul_state_e;

  // sub-product slots in issue order
  localparam int unsigned SLOT_LO  = 0;
  localparam int unsigned SLOT_MID = 1;
  localparam int unsigned SLOT_HI  = 2;
  localparam int unsigned N_SLOTS  = 3;
endpackage

// File: rtl/gf128_clmul.sv
// Combinational W x W carryless multiplier producing a 2W-bit polynomial.
module gf128_clmul #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int unsigned PW = 2 * W;

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (y[i]) p = p ^ ({{W{1'b0}}, x} << i);
    end
  end
endmodule

// File: rtl/gf128_recombine.sv
// Karatsuba middle-term correction and overlap of the three sub-products.
module gf128_recombine #(
  parameter int unsigned HW = 64
) (
  input  logic [2*HW-1:0] z_lo,
  input  logic [2*HW-1:0] z_mid,
  input  logic [2*HW-1:0] z_hi,
  output logic [4*HW-1:0] prod
);
  localparam int unsigned FW = 2 * HW;

  logic [FW-1:0] mid_fix;
  logic [FW-1:0] low_half;
  logic [FW-1:0] high_half;

  always_comb begin
    mid_fix   = z_mid ^ z_lo ^ z_hi;
    low_half  = z_lo ^ (mid_fix << HW);
    high_half = z_hi ^ (mid_fix >> HW);
    prod      = {high_half, low_half};
  end
endmodule

// File: rtl/gf128_reduce.sv
// Shift-and-XOR long division of a 2W-bit polynomial by x^W + TAPS,
// highest degree first so that folds which land above W-1 are folded again.
module gf128_reduce #(
  parameter int unsigned    W     = 128,
  parameter int unsigned    TAP_W = 8,
  parameter logic [TAP_W-1:0] TAPS = 8'h87
) (
  input  logic [2*W-1:0] wide,
  output logic [W-1:0]   narrow
);
  logic [2*W-1:0] work;

  always_comb begin
    work = wide;
    for (int k = 2 * W - 1; k >= int'(W); k--) begin
      if (work[k]) begin
        for (int j = 0; j < int'(TAP_W); j++) begin
          if (TAPS[j]) work[k - int'(W) + j] = ~work[k - int'(W) + j];
        end
      end
    end
    narrow = work[W-1:0];
  end
endmodule

// File: rtl/gf128_kmul.sv
module gf128_kmul
  import gf128_kmul_pkg::*;
#(
  parameter int unsigned      FW       = 128,
  parameter bit               PARALLEL = 1'b0,
  parameter int unsigned      TAP_W    = 8,
  parameter logic [TAP_W-1:0] TAPS     = 8'h87
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output logic          done,
  output logic [FW-1:0] result
);
  localparam int unsigned HW  = FW / 2;
  localparam int unsigned LAT = PARALLEL ? 2 : 4;

  kmul_state_e state;
  logic [1:0]  slot;
  logic        busy;
  logic        accept;
  logic        last_mul;

  logic [FW-1:0] op_a_q, op_b_q;
  logic [HW-1:0] a_lo, a_hi, b_lo, b_hi;

  logic [FW-1:0]      z_q   [N_SLOTS];
  logic [FW-1:0]      z_new [N_SLOTS];
  logic [N_SLOTS-1:0] z_we;

  logic [2*FW-1:0] wide_prod;
  logic [FW-1:0]   reduced;

  assign busy   = (state != ST_IDLE);
  assign accept = start && !busy;

  assign a_lo = op_a_q[HW-1:0];
  assign a_hi = op_a_q[FW-1:HW];
  assign b_lo = op_b_q[HW-1:0];
  assign b_hi = op_b_q[FW-1:HW];

  // ---------------- sub-product arithmetic ----------------
  if (PARALLEL) begin : g_par
    gf128_clmul #(.W(HW)) u_mul_lo  (.x(a_lo),        .y(b_lo),        .p(z_new[SLOT_LO]));
    gf128_clmul #(.W(HW)) u_mul_mid (.x(a_lo ^ a_hi), .y(b_lo ^ b_hi), .p(z_new[SLOT_MID]));
    gf128_clmul #(.W(HW)) u_mul_hi  (.x(a_hi),        .y(b_hi),        .p(z_new[SLOT_HI]));

    assign z_we     = (state == ST_MUL) ? {N_SLOTS{1'b1}} : '0;
    assign last_mul = 1'b1;
  end else begin : g_shared
    logic [HW-1:0] sel_x, sel_y;
    logic [FW-1:0] shared_p;

    always_comb begin
      unique case (slot)
        2'd0:    begin sel_x = a_lo;        sel_y = b_lo;        end
        2'd1:    begin sel_x = a_lo ^ a_hi; sel_y = b_lo ^ b_hi; end
        default: begin sel_x = a_hi;        sel_y = b_hi;        end
      endcase
    end

    gf128_clmul #(.W(HW)) u_mul (.x(sel_x), .y(sel_y), .p(shared_p));

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      assign z_new[s] = shared_p;
      assign z_we[s]  = (state == ST_MUL) && (slot == 2'(s));
    end
    assign last_mul = (slot == 2'(N_SLOTS - 1));
  end

  gf128_recombine #(.HW(HW)) u_recomb (
    .z_lo (z_q[SLOT_LO]),
    .z_mid(z_q[SLOT_MID]),
    .z_hi (z_q[SLOT_HI]),
    .prod (wide_prod)
  );

  gf128_reduce #(.W(FW), .TAP_W(TAP_W), .TAPS(TAPS)) u_reduce (
    .wide  (wide_prod),
    .narrow(reduced)
  );

  // ---------------- sub-product registers ----------------
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_zreg
    always_ff @(posedge clk) begin
      if (rst)          z_q[s] <= '0;
      else if (z_we[s]) z_q[s] <= z_new[s];
    end
  end

  // ---------------- controller ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      slot   <= '0;
      op_a_q <= '0;
      op_b_q <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            op_a_q <= a;
            op_b_q <= b;
            slot   <= '0;
            state  <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (last_mul) state <= ST_RED;
          else          slot  <= slot + 2'd1;
        end
        ST_RED: begin
          result <= reduced;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf128_kmul_chk.sv
module gf128_kmul_chk #(
  parameter int unsigned FW  = 128,
  parameter int unsigned LAT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [FW-1:0] result,
  input logic [FW-1:0] op_a_q,
  input logic [FW-1:0] op_b_q
);
  localparam int unsigned CW = $clog2(LAT + 1);
  localparam logic [FW-1:0] ONE = FW'(1);

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst)                                 lat_cnt <= '0;
    else if (start && !busy)                 lat_cnt <= CW'(1);
    else if (done)                           lat_cnt <= '0;
    else if (lat_cnt != '0 && lat_cnt < CW'(LAT)) lat_cnt <= lat_cnt + CW'(1);
  end

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == CW'(LAT)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_a_q) && $stable(op_b_q)));

  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (op_a_q == '0 || op_b_q == '0)) |-> (result == '0));

  // R4
  unit_a_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_a_q == ONE) |-> (result == op_b_q));

  // R4
  unit_b_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_b_q == ONE) |-> (result == op_a_q));
endmodule

bind gf128_kmul gf128_kmul_chk #(.FW(FW), .LAT(LAT)) u_kmul_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .result(result),
  .op_a_q(op_a_q),
  .op_b_q(op_b_q)
);

// File: tb/test_gf128_kmul.sv
`timescale 1ns/1ps
module test_gf128_kmul;
  localparam int unsigned FW       = 128;
  localparam int          EXP_WAIT = 5; // negedges after the drive edge: 4 clock edges of latency

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [FW-1:0] a = '0;
  logic [FW-1:0] b = '0;
  logic          done;
  logic [FW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  gf128_kmul i_gf128_kmul (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b),
    .done(done), .result(result)
  );

  // bit-serial reference: multiply-by-x with reduction at every step
  function automatic logic [FW-1:0] model_mul(input logic [FW-1:0] x, input logic [FW-1:0] y);
    logic [FW-1:0] r;
    logic          c;
    r = '0;
    for (int i = FW - 1; i >= 0; i--) begin
      c = r[FW-1];
      r = r << 1;
      if (c) r = r ^ 128'h87;
      if (y[i]) r = r ^ x;
    end
    return r;
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request, wait for done, check latency, value, pulse width and hold
  task automatic run_one(input string req, input logic [FW-1:0] x, input logic [FW-1:0] y);
    int waited;
    logic [FW-1:0] exp;
    exp = model_mul(x, y);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~x; b = y ^ 128'h5A5A; // R9: operands change after capture
    waited = 1;
    while (!done && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check({req, " R2 latency"}, FW'(waited), FW'(EXP_WAIT));
    check({req, " R3/R9 value"}, result, exp);
    @(negedge clk);
    check({req, " R2 pulse width"}, FW'(done), FW'(0));
    check({req, " R7 hold"}, result, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done in reset", FW'(done), FW'(0));
    check("R1 result in reset", result, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 done after reset", FW'(done), FW'(0));
    check("R1 result after reset", result, '0);
  endtask

  task automatic t_identity;
    logic [FW-1:0] v;
    v = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98;
    run_one("R4 a=1", 128'h1, v);
    check("R4 a=1 passes b", result, v);
    run_one("R4 b=1", v, 128'h1);
    check("R4 b=1 passes a", result, v);
  endtask

  task automatic t_zero;
    run_one("R5 a=0", '0, 128'hFFFF_0000_1234_5678_9ABC_DEF0_0F0F_F0F0);
    check("R5 a=0 gives zero", result, '0);
    run_one("R5 b=0", 128'h8000_0000_0000_0000_0000_0000_0000_0001, '0);
    check("R5 b=0 gives zero", result, '0);
  endtask

  task automatic t_high_degree;
    run_one("R8 x127*x127", 128'h1 << 127, 128'h1 << 127);
    run_one("R8 ones*ones", '1, '1);
    run_one("R8 top byte", 128'hFF << 120, 128'hFE << 120);
    run_one("R3 x*x127", 128'h2, 128'h1 << 127);
    check("R3 x*x^127 = 0x87", result, 128'h87);
  endtask

  task automatic t_random;
    logic [FW-1:0] x, y;
    for (int n = 0; n < 8; n++) begin
      rng = next_rng(rng); x[63:0]   = rng;
      rng = next_rng(rng); x[127:64] = rng;
      rng = next_rng(rng); y[63:0]   = rng;
      rng = next_rng(rng); y[127:64] = rng;
      run_one("R3 random", x, y);
    end
    // halves equal, so the middle product is zero
    run_one("R3 equal halves", {2{64'hC3A5_0F1E_7788_9911}}, {2{64'h1234_8765_ABCD_EF01}});
  endtask

  task automatic t_busy_ignore;
    logic [FW-1:0] x, y, exp;
    int pulses;
    x = 128'h0123_4567_89AB_CDEF_1122_3344_5566_7788;
    y = 128'hA5A5_5A5A_F00F_0FF0_1357_9BDF_2468_ACE0;
    exp = model_mul(x, y);
    pulses = 0;
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    a = 128'h1; b = 128'h3; // new request while computing
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 10; n++) begin
      if (done) begin
        pulses++;
        check("R6 result keeps first product", result, exp);
      end
      @(negedge clk);
    end
    check("R6 single done pulse", FW'(pulses), FW'(1));
    check("R7 result held after", result, exp);
  endtask

  initial begin
    t_reset();
    t_identity();
    t_zero();
    t_high_degree();
    t_random();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule